// File: doc/BRIEF.md
# Display Post-Processing Sub-Block Flush Controller

This block holds the colour-processing configuration for a group of display post-processing units and decides when each part of it takes effect. Every unit has three colour sub-blocks: inverse gamma, panel colour correction and gamma. Each sub-block has a shadow register that software writes freely and an active register that feeds the pixel pipeline. Software fills the shadows and arms the sub-blocks it wants in each unit's own flush register. It then sets the master qualifier bit in the main flush register.

On the next frame-boundary strobe, a sub-block is copied from shadow to active only if its own flush bit and the master qualifier are both pending. All bits that were consumed then clear themselves. Software can poll the flush registers to see when a commit has completed. A build-time parameter selects a legacy variant instead. In that variant a single main-register bit refreshes the whole first unit, and the per-unit registers do nothing.

Top module: `pp_subblk_flush`

## Requirements
- R1: When the master qualifier is pending at a frame strobe, every armed sub-block's active register takes its shadow value. The change is visible on `activeCfg` right after that clock edge, and `activeCfg` changes at no other time.
- R2: Sub-blocks that are not armed keep their active value through a commit. In a unit flush register, only bit 2 (inverse gamma), bit 4 (panel colour) and bit 5 (gamma) are stored. Every other bit is dropped and reads back as 0.
- R3: The map is as follows. The main flush register is at 0x018. The flush register for unit n is at 0x13C + 4n. The shadow for unit n, sub-block s is at 0x400 + 16n + 4s, where s is 0 for inverse gamma, 1 for panel colour and 2 for gamma. That shadow's active value drives `activeCfg[(3n+s)*32 +: 32]`. In sub-block mode, bit 29 of the main register is the master qualifier.
- R4: A frame strobe with no master qualifier pending changes no active register, and the armed unit bits stay pending.
- R5: A commit with the master qualifier set but all unit masks zero changes no active register, and it still clears the master bit.
- R6: After a commit, the main register and every unit register whose bits were applied read 0.
- R7: Reading a flush register returns its pending bits. Reading a shadow address returns the shadow value.
- R8: A write in the same cycle as a frame strobe does not affect that strobe. The strobe uses the register contents from before the write, and the written value stays for the next frame.
- R9: In the legacy variant (`SUB_FLUSH_EN` = 0), only bit 13 of the main register is stored. A strobe with bit 13 pending copies all three shadows of unit 0 to active and clears bit 13. Bit 29 and the unit flush registers have no effect, and the unit flush registers read 0.
- R10: Writes to unmapped addresses are ignored and reads from them return 0. This includes unit flush addresses at or beyond `NUM_UNITS`.
- R11: Reset clears all shadow, active and pending state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write enable for this cycle |
| busAddr | input | ADDR_W | Register byte address for write and read |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Combinational read data for `busAddr` |
| frameStrobe | input | 1 | One-cycle frame-boundary pulse |
| activeCfg | output | NUM_UNITS*3*DATA_W | Active sub-block configuration, one word per unit and sub-block |

## Verification
The bench targets the following corner cases:
- **Strobe without the master qualifier.** A design that ignores the qualifier would apply the armed unit.
- **Master qualifier with empty unit masks.** A faulty design would leave the master bit stuck or apply something.
- **Junk bits outside positions 2, 4 and 5.** A faulty design would arm the wrong sub-block.
- **Writes to the flush or shadow registers in the same cycle as the strobe.** A wrong priority would either lose the new value or commit it one frame early.
- **The address one past the last unit.** Sloppy decoding would alias it onto a real unit.
- **The legacy variant.** A faulty design would honour bit 29 or the per-unit registers, or fail to refresh all of unit 0.

// File: rtl/pp_flush_pkg.sv
package pp_flush_pkg;
  // Number of colour sub-blocks per post-processing unit
  localparam int NUM_SUB = 3;

  // Sub-block ordering used for shadow addresses and activeCfg slices
  localparam int SUB_INVGAM = 0;
  localparam int SUB_PANEL  = 1;
  localparam int SUB_GAMMA  = 2;

  // Register map (byte addresses)
  localparam int MAIN_FLUSH_ADDR = 'h018;
  localparam int UNIT_FLUSH_BASE = 'h13C;
  localparam int UNIT_FLUSH_STEP = 4;
  localparam int SHADOW_BASE     = 'h400;
  localparam int SHADOW_UNIT_STEP = 16;
  localparam int SHADOW_SUB_STEP  = 4;

  // Main flush register bit positions
  localparam int MASTER_SUB_BIT = 29;
  localparam int LEGACY_BIT     = 13;

  // Position of a sub-block's arm bit inside a unit flush register
  function automatic int subFlushBit(input int s);
    case (s)
      SUB_INVGAM: return 2;
      SUB_PANEL:  return 4;
      default:    return 5;
    endcase
  endfunction

  // Strobes from the control side to the configuration store
  typedef struct packed {
    logic wr;      // register write this cycle
    logic commit;  // frame strobe with the qualifier pending
  } flush_stb_t;
endpackage

// File: rtl/pp_flush_regs.sv
module pp_flush_regs
  import pp_flush_pkg::*;
#(
  parameter int NUM_UNITS    = 4,
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 32,
  parameter bit SUB_FLUSH_EN = 1'b1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWe,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWdata,
  input  logic                          frameStrobe,
  output flush_stb_t                    ctrlStb,
  output logic [NUM_UNITS*NUM_SUB-1:0]  armMask,
  output logic [DATA_W-1:0]             regRdata
);
  localparam int MAIN_BIT = SUB_FLUSH_EN ? MASTER_SUB_BIT : LEGACY_BIT;
  localparam int ARM_W    = NUM_UNITS * NUM_SUB;

  logic                 mainPend;
  logic                 mainHit;
  logic                 commitNow;
  logic [NUM_UNITS-1:0] unitHit;
  logic [ARM_W-1:0]     unitPend;
  logic                 unusedWdata;

  assign unusedWdata = ^busWdata;
  assign mainHit     = (busAddr == ADDR_W'(MAIN_FLUSH_ADDR));
  assign commitNow   = frameStrobe & mainPend;

  assign ctrlStb.wr     = busWe;
  assign ctrlStb.commit = commitNow;

  // Write wins over self-clear: a write in the strobe cycle stays pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  mainPend <= 1'b0;
    else if (busWe && mainHit)  mainPend <= busWdata[MAIN_BIT];
    else if (commitNow)         mainPend <= 1'b0;
  end

  for (genvar n = 0; n < NUM_UNITS; n++) begin : g_unit
    localparam logic [ADDR_W-1:0] UNIT_ADDR =
      ADDR_W'(UNIT_FLUSH_BASE + n * UNIT_FLUSH_STEP);
    assign unitHit[n] = (busAddr == UNIT_ADDR);

    if (SUB_FLUSH_EN) begin : g_sub
      logic [NUM_SUB-1:0] wrMask;
      always_comb
        for (int s = 0; s < NUM_SUB; s++)
          wrMask[s] = busWdata[subFlushBit(s)];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                      unitPend[n*NUM_SUB +: NUM_SUB] <= '0;
        else if (busWe && unitHit[n])   unitPend[n*NUM_SUB +: NUM_SUB] <= wrMask;
        else if (commitNow)             unitPend[n*NUM_SUB +: NUM_SUB] <= '0;
      end
      assign armMask[n*NUM_SUB +: NUM_SUB] = unitPend[n*NUM_SUB +: NUM_SUB];
    end else begin : g_legacy
      assign unitPend[n*NUM_SUB +: NUM_SUB] = '0;
      assign armMask[n*NUM_SUB +: NUM_SUB]  = (n == 0) ? '1 : '0;
    end
  end

  always_comb begin
    regRdata = '0;
    if (mainHit) regRdata[MAIN_BIT] = mainPend;
    for (int n = 0; n < NUM_UNITS; n++)
      if (unitHit[n])
        for (int s = 0; s < NUM_SUB; s++)
          regRdata[subFlushBit(s)] = unitPend[n*NUM_SUB + s];
  end
endmodule

// File: rtl/pp_cfg_store.sv
module pp_cfg_store
  import pp_flush_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [ADDR_W-1:0]                   busAddr,
  input  logic [DATA_W-1:0]                   busWdata,
  input  flush_stb_t                          ctrlStb,
  input  logic [NUM_UNITS*NUM_SUB-1:0]        armMask,
  output logic [DATA_W-1:0]                   shadowRdata,
  output logic [NUM_UNITS*NUM_SUB*DATA_W-1:0] activeCfg
);
  localparam int SLOTS = NUM_UNITS * NUM_SUB;

  logic [SLOTS-1:0]  slotHit;
  logic [DATA_W-1:0] shadowQ [SLOTS];
  logic [DATA_W-1:0] activeQ [SLOTS];

  for (genvar n = 0; n < NUM_UNITS; n++) begin : g_unit
    for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
      localparam int IDX = n * NUM_SUB + s;
      localparam logic [ADDR_W-1:0] SH_ADDR =
        ADDR_W'(SHADOW_BASE + n * SHADOW_UNIT_STEP + s * SHADOW_SUB_STEP);

      assign slotHit[IDX] = (busAddr == SH_ADDR);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          shadowQ[IDX] <= '0;
        else if (ctrlStb.wr && slotHit[IDX]) shadowQ[IDX] <= busWdata;
      end

      // Transfer uses the shadow value held before any same-cycle write
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                              activeQ[IDX] <= '0;
        else if (ctrlStb.commit && armMask[IDX]) activeQ[IDX] <= shadowQ[IDX];
      end

      assign activeCfg[IDX*DATA_W +: DATA_W] = activeQ[IDX];
    end
  end

  always_comb begin
    shadowRdata = '0;
    for (int i = 0; i < SLOTS; i++)
      if (slotHit[i]) shadowRdata = shadowQ[i];
  end
endmodule

// File: rtl/pp_subblk_flush.sv
module pp_subblk_flush
  import pp_flush_pkg::*;
#(
  parameter int NUM_UNITS    = 4,
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 32,
  parameter bit SUB_FLUSH_EN = 1'b1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                busWe,
  input  logic [ADDR_W-1:0]                   busAddr,
  input  logic [DATA_W-1:0]                   busWdata,
  output logic [DATA_W-1:0]                   busRdata,
  input  logic                                frameStrobe,
  output logic [NUM_UNITS*NUM_SUB*DATA_W-1:0] activeCfg
);
  flush_stb_t                   ctrlStb;
  logic [NUM_UNITS*NUM_SUB-1:0] armMask;
  logic [DATA_W-1:0]            regRdata;
  logic [DATA_W-1:0]            shadowRdata;

  pp_flush_regs #(
    .NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SUB_FLUSH_EN(SUB_FLUSH_EN)
  ) uRegs (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .frameStrobe(frameStrobe),
    .ctrlStb(ctrlStb), .armMask(armMask), .regRdata(regRdata)
  );

  pp_cfg_store #(
    .NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uStore (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .ctrlStb(ctrlStb), .armMask(armMask),
    .shadowRdata(shadowRdata), .activeCfg(activeCfg)
  );

  assign busRdata = regRdata | shadowRdata;
endmodule

// File: rtl/pp_flush_chk.sv
module pp_flush_chk
  import pp_flush_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input logic                                clk,
  input logic                                rstN,
  input logic                                busWe,
  input logic [ADDR_W-1:0]                   busAddr,
  input logic [DATA_W-1:0]                   busRdata,
  input logic                                frameStrobe,
  input logic [NUM_UNITS*NUM_SUB*DATA_W-1:0] activeCfg,
  input logic [NUM_UNITS*NUM_SUB-1:0]        armMask,
  input logic                                commitNow
);
  logic mapped;
  always_comb begin
    mapped = (busAddr == ADDR_W'(MAIN_FLUSH_ADDR));
    for (int n = 0; n < NUM_UNITS; n++) begin
      if (busAddr == ADDR_W'(UNIT_FLUSH_BASE + n * UNIT_FLUSH_STEP)) mapped = 1'b1;
      for (int s = 0; s < NUM_SUB; s++)
        if (busAddr == ADDR_W'(SHADOW_BASE + n * SHADOW_UNIT_STEP + s * SHADOW_SUB_STEP))
          mapped = 1'b1;
    end
  end

  // R1
  act_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> $stable(activeCfg));

  for (genvar i = 0; i < NUM_UNITS * NUM_SUB; i++) begin : g_slot
    // R2
    slice_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(commitNow && armMask[i]) |=> $stable(activeCfg[i*DATA_W +: DATA_W]));
  end

  // R6
  main_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && !busWe) ##1 (!busWe && busAddr == ADDR_W'(MAIN_FLUSH_ADDR))
      |-> busRdata == '0);

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> busRdata == '0);
endmodule

bind pp_subblk_flush pp_flush_chk #(
  .NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .busRdata(busRdata), .frameStrobe(frameStrobe), .activeCfg(activeCfg),
  .armMask(armMask), .commitNow(ctrlStb.commit)
);

// File: tb/tb_pp_subblk_flush.sv
`timescale 1ns/1ps
module tb_pp_subblk_flush;
  localparam int NU = 4;
  localparam int NS = 3;
  localparam int AW = 12;
  localparam int DW = 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           busWe = 1'b0;
  logic [AW-1:0]  busAddr = '0;
  logic [DW-1:0]  busWdata = '0;
  logic           frameStrobe = 1'b0;
  logic [DW-1:0]  busRdata, legRdata;
  logic [NU*NS*DW-1:0] activeCfg, legActive;

  int checks = 0;
  int fails  = 0;

  // Bench model of the sub-block variant
  logic [DW-1:0] shadowM [NU][NS];
  logic [DW-1:0] activeM [NU][NS];
  logic [NS-1:0] unitM   [NU];
  logic          mainM;

  always #2 clk = ~clk;

  pp_subblk_flush #(.NUM_UNITS(NU), .ADDR_W(AW), .DATA_W(DW), .SUB_FLUSH_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .frameStrobe(frameStrobe), .activeCfg(activeCfg));

  pp_subblk_flush #(.NUM_UNITS(NU), .ADDR_W(AW), .DATA_W(DW), .SUB_FLUSH_EN(1'b0)) dutLeg (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(legRdata), .frameStrobe(frameStrobe), .activeCfg(legActive));

  function automatic logic [AW-1:0] shAddr(int n, int s);
    return AW'('h400 + 16 * n + 4 * s);
  endfunction

  function automatic logic [AW-1:0] unAddr(int n);
    return AW'('h13C + 4 * n);
  endfunction

  function automatic logic [NU*NS*DW-1:0] expAct();
    logic [NU*NS*DW-1:0] v;
    for (int n = 0; n < NU; n++)
      for (int s = 0; s < NS; s++)
        v[(n*NS+s)*DW +: DW] = activeM[n][s];
    return v;
  endfunction

  function automatic logic [DW-1:0] expRd(logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    if (a == 12'h018) r[29] = mainM;
    for (int n = 0; n < NU; n++) begin
      if (a == unAddr(n)) begin
        r[2] = unitM[n][0]; r[4] = unitM[n][1]; r[5] = unitM[n][2];
      end
      for (int s = 0; s < NS; s++)
        if (a == shAddr(n, s)) r = shadowM[n][s];
    end
    return r;
  endfunction

  task automatic modelReset();
    for (int n = 0; n < NU; n++) begin
      unitM[n] = '0;
      for (int s = 0; s < NS; s++) begin
        shadowM[n][s] = '0; activeM[n][s] = '0;
      end
    end
    mainM = 1'b0;
  endtask

  task automatic cmp(string tag, logic [NU*NS*DW-1:0] act, logic [NU*NS*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit we, logic [AW-1:0] a, logic [DW-1:0] d, bit fs, string tag);
    @(negedge clk);
    busWe = we; busAddr = a; busWdata = d; frameStrobe = fs;
    @(posedge clk);
    if (fs && mainM) begin
      for (int n = 0; n < NU; n++) begin
        for (int s = 0; s < NS; s++)
          if (unitM[n][s]) activeM[n][s] = shadowM[n][s];
        unitM[n] = '0;
      end
      mainM = 1'b0;
    end
    if (we) begin
      if (a == 12'h018) mainM = d[29];
      for (int n = 0; n < NU; n++) begin
        if (a == unAddr(n)) unitM[n] = {d[5], d[4], d[2]};
        for (int s = 0; s < NS; s++)
          if (a == shAddr(n, s)) shadowM[n][s] = d;
      end
    end
    #1;
    cmp(tag, activeCfg, expAct());
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    @(negedge clk);
    busWe = 1'b0; frameStrobe = 1'b0; busAddr = a;
    #1;
    cmp(tag, {{(NU*NS*DW-DW){1'b0}}, busRdata}, {{(NU*NS*DW-DW){1'b0}}, expRd(a)});
  endtask

  task automatic rdLeg(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    @(negedge clk);
    busWe = 1'b0; frameStrobe = 1'b0; busAddr = a;
    #1;
    cmp(tag, {{(NU*NS*DW-DW){1'b0}}, legRdata}, {{(NU*NS*DW-DW){1'b0}}, exp});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busWe = 1'b0; frameStrobe = 1'b0;
    modelReset();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [NU*NS*DW-1:0] legExp;
    void'($urandom(32'h5EED_0017));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    #1 cmp("R11 active", activeCfg, '0);
    rd(12'h018, "R11 main");
    rd(unAddr(0), "R11 unit");
    rd(shAddr(3, 2), "R11 shadow");

    // R4 armed unit without master qualifier
    step(1, shAddr(2, 1), 32'hCAFE_0001, 0, "R7 shadow wr");
    step(1, unAddr(2), 32'h0000_0010, 0, "R3 unit arm");
    step(0, 12'h000, '0, 1, "R4 no master");
    rd(unAddr(2), "R4 still pending");
    // R1 with the qualifier
    step(1, 12'h018, 32'h2000_0000, 0, "R3 master");
    rd(12'h018, "R7 main pending");
    step(0, 12'h000, '0, 1, "R1 commit");
    rd(unAddr(2), "R6 unit cleared");
    rd(12'h018, "R6 main cleared");

    // R5 master with empty masks
    step(1, 12'h018, 32'h2000_0000, 0, "R5 master");
    step(0, 12'h000, '0, 1, "R5 commit empty");
    rd(12'h018, "R5 main cleared");

    // R2 junk bits and partial arm
    for (int s = 0; s < NS; s++) step(1, shAddr(1, s), 32'h1111_0000 + s, 0, "R2 shadow");
    step(1, unAddr(1), 32'hFFFF_FFCB, 0, "R2 junk");
    rd(unAddr(1), "R2 junk reads zero");
    step(1, 12'h018, 32'hDFFF_FFFF, 0, "R2 main junk");
    rd(12'h018, "R2 main junk");
    step(1, unAddr(1), 32'h0000_0020, 0, "R2 gamma arm");
    step(1, 12'h018, 32'h2000_0000, 0, "R2 master");
    step(0, 12'h000, '0, 1, "R2 gamma only");

    // R8 main write in strobe cycle, then shadow write in strobe cycle
    step(1, shAddr(3, 0), 32'hAAAA_0000, 0, "R8 shadow");
    step(1, unAddr(3), 32'h0000_0004, 0, "R8 arm");
    step(1, 12'h018, 32'h2000_0000, 1, "R8 main same cycle");
    rd(12'h018, "R8 main held");
    step(1, shAddr(3, 0), 32'hBBBB_0000, 1, "R8 shadow same cycle");
    rd(shAddr(3, 0), "R8 new shadow kept");
    step(1, unAddr(3), 32'h0000_0004, 0, "R8 rearm");
    step(1, 12'h018, 32'h2000_0000, 0, "R8 master");
    step(1, unAddr(3), 32'h0000_0000, 1, "R8 unit write same cycle");
    rd(unAddr(3), "R8 unit write kept");

    // R10 unit index beyond range and unmapped space
    step(1, 12'h14C, 32'h0000_0034, 0, "R10 unit4");
    step(1, 12'h500, 32'hDEAD_BEEF, 0, "R10 unmapped");
    step(1, 12'h018, 32'h2000_0000, 0, "R10 master");
    step(0, 12'h000, '0, 1, "R10 commit");
    rd(12'h14C, "R10 unit4 read");
    rd(12'h500, "R10 unmapped read");

    // Random mix
    for (int i = 0; i < 2500; i++) begin
      int op = $urandom_range(0, 9);
      int n  = $urandom_range(0, NU - 1);
      int s  = $urandom_range(0, NS - 1);
      bit fs = ($urandom_range(0, 4) == 0);
      logic [DW-1:0] d = $urandom;
      if (op <= 2)      step(1, shAddr(n, s), d, fs, "R1 rand shadow");
      else if (op <= 4) step(1, unAddr(n),
                             $urandom_range(0, 1) ? d : DW'(1) << (2 + 2 * s - (s == 2 ? 1 : 0)),
                             fs, "R2 rand arm");
      else if (op == 5) step(1, 12'h018, {2'b0, 1'($urandom_range(0, 2) != 0), d[28:0]}, fs, "R4 rand main");
      else if (op == 6) step(1, $urandom_range(0, 1) ? 12'h14C : 12'h300, d, fs, "R10 rand unmapped");
      else              step(0, 12'h000, '0, fs, "R1 rand idle");
      if (i % 3 == 0) begin
        int pick = $urandom_range(0, 3);
        rd(pick == 0 ? 12'h018 : pick == 1 ? unAddr(n) : pick == 2 ? shAddr(n, s) : 12'h14C,
           "R7 rand read");
      end
    end

    // R9 legacy variant (both designs see the same stimulus)
    doReset();
    step(1, shAddr(0, 0), 32'hA000_0000, 0, "R9 sh0");
    step(1, shAddr(0, 1), 32'hA000_0001, 0, "R9 sh1");
    step(1, shAddr(0, 2), 32'hA000_0002, 0, "R9 sh2");
    step(1, shAddr(1, 0), 32'hB000_0000, 0, "R9 sh3");
    step(1, unAddr(1), 32'h0000_0034, 0, "R9 unit arm");
    rdLeg(unAddr(1), 32'h0, "R9 legacy unit reg ignored");
    step(1, 12'h018, 32'h2000_0000, 0, "R9 bit29");
    rdLeg(12'h018, 32'h0, "R9 legacy bit29 ignored");
    step(0, 12'h000, '0, 1, "R9 strobe");
    cmp("R9 legacy no commit", legActive, '0);
    step(1, 12'h018, 32'h0000_2000, 0, "R9 bit13");
    rdLeg(12'h018, 32'h0000_2000, "R9 legacy bit13 pending");
    step(0, 12'h000, '0, 1, "R9 strobe2");
    legExp = '0;
    legExp[0 +: DW]    = 32'hA000_0000;
    legExp[DW +: DW]   = 32'hA000_0001;
    legExp[2*DW +: DW] = 32'hA000_0002;
    cmp("R9 legacy unit0 refresh", legActive, legExp);
    rdLeg(12'h018, 32'h0, "R9 legacy bit13 cleared");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule